// File: doc/BRIEF.md
# Register Rename Stage with Free Pool and Branch Snapshot

This block renames one instruction per cycle. It keeps a table that maps each of 32 architectural registers to one of 48 physical registers. An instruction that writes a destination is given a fresh physical register. That register is taken from the head of a first-in first-out pool of unused indices. Because each write lands in a new location, write-after-read and write-after-write conflicts between instructions disappear. Read-after-write ordering is kept, because source operands are looked up through the mapping in force when the instruction arrives.

For every rename the stage reports the physical register that the destination was mapped to before. The commit logic hands that index back through a release port once the older value is superseded and nothing still reads it. The stage can take one snapshot of the table and the pool's head position, normally at a branch. On a mispredict it returns to that snapshot in a single cycle.

Top module: `rename_stage`

## Requirements
- R1: After reset, architectural register n maps to physical register n, and the pool hands out physical registers 32, 33, …, 47 in ascending order.
- R2: `ren_src1_phys` and `ren_src2_phys` give the current mapping of `ren_src1` and `ren_src2` combinationally, in the same cycle, and include every rename accepted in earlier cycles.
- R3: A valid, unstalled instruction with `ren_wr`=1 and a nonzero `ren_dst` is given the pool's head index on `ren_new_phys`. Later reads of that destination return the new index. In every other cycle `ren_new_phys` is 0.
- R4: `ren_old_phys` is the mapping of `ren_dst` as it was before the current instruction.
- R5: When an instruction reads and writes the same architectural register, the source translation uses the mapping from before its own allocation.
- R6: Architectural register 0 is never renamed. A write to it consumes no pool entry, and a read of it always returns physical register 0.
- R7: `ren_stall` is 1 when a valid instruction needs a new register and the pool is empty. A stalled instruction changes no state. An instruction that needs no register is not stalled by an empty pool, and a release in the same cycle does not lift the stall.
- R8: A pulse on `rel_valid` appends `rel_phys` to the pool's tail. Released indices are handed out again in the order they were released, after those already waiting.
- R9: `ckpt_save` records the table and the pool head as they stand after that cycle's rename. `ckpt_restore` brings both back in one cycle. Releases in the restore cycle are kept. A valid instruction in the restore cycle is refused with `ren_stall`=1. If both strobes are high, the restore wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ren_valid | input | 1 | An instruction is presented for renaming |
| ren_wr | input | 1 | The instruction writes a destination |
| ren_dst | input | 5 | Architectural destination |
| ren_src1 | input | 5 | Architectural first source |
| ren_src2 | input | 5 | Architectural second source |
| ren_stall | output | 1 | Instruction refused this cycle; hold it |
| ren_src1_phys | output | 6 | Physical first source |
| ren_src2_phys | output | 6 | Physical second source |
| ren_new_phys | output | 6 | Newly allocated physical destination, 0 if none |
| ren_old_phys | output | 6 | Previous physical mapping of the destination |
| rel_valid | input | 1 | Return an index to the pool |
| rel_phys | input | 6 | Physical register being returned |
| ckpt_save | input | 1 | Take the snapshot |
| ckpt_restore | input | 1 | Return to the snapshot |

## Verification
The hardest state to reach is a restore that follows a long run of renames and releases. In that state the pool has wrapped, may have been empty, and holds released indices behind the snapshot head. A wrong release order or pointer slip only shows up many cycles later, as a duplicated register. The random phase gets there with a reference model that records the outstanding old mappings. It releases only those older than the live snapshot and discards the younger ones on each restore, so long legal streams keep filling, draining and rewinding the pool. Directed steps cover the exact empty-pool stall, a same-register read and write, register 0, and a release in the restore cycle.

// File: rtl/rn_pkg.sv
package rn_pkg;
  localparam int DEF_ARCH_REGS = 32;
  localparam int DEF_PHYS_REGS = 48;

  function automatic int pool_depth(input int arch_n, input int phys_n);
    return phys_n - arch_n;
  endfunction
endpackage

// File: rtl/rn_map_table.sv
module rn_map_table #(
  parameter int ARCH_N = 32,
  parameter int PHYS_N = 48,
  localparam int AW = $clog2(ARCH_N),
  localparam int PW = $clog2(PHYS_N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] rd_a1,
  input  logic [AW-1:0] rd_a2,
  input  logic [AW-1:0] rd_a3,
  output logic [PW-1:0] rd_d1,
  output logic [PW-1:0] rd_d2,
  output logic [PW-1:0] rd_d3,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_a,
  input  logic [PW-1:0] wr_d,
  input  logic          save_en,
  input  logic          restore_en
);
  logic [PW-1:0] map_q [ARCH_N];
  logic [PW-1:0] map_d [ARCH_N];
  logic [PW-1:0] snap_q [ARCH_N];
  logic [PW-1:0] snap_d [ARCH_N];

  // reads see the table before this cycle's write
  assign rd_d1 = map_q[rd_a1];
  assign rd_d2 = map_q[rd_a2];
  assign rd_d3 = map_q[rd_a3];

  always_comb begin
    for (int i = 0; i < ARCH_N; i++) begin
      if (restore_en)
        map_d[i] = snap_q[i];
      else if (wr_en && (wr_a == AW'(i)))
        map_d[i] = wr_d;
      else
        map_d[i] = map_q[i];
      snap_d[i] = save_en ? map_d[i] : snap_q[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ARCH_N; i++) begin
        map_q[i]  <= PW'(i);
        snap_q[i] <= PW'(i);
      end
    end else begin
      for (int i = 0; i < ARCH_N; i++) begin
        map_q[i]  <= map_d[i];
        snap_q[i] <= snap_d[i];
      end
    end
  end
endmodule

// File: rtl/rn_free_list.sv
module rn_free_list #(
  parameter int DEPTH = 16,
  parameter int PW    = 6,
  parameter int BASE  = 32,
  localparam int IW = $clog2(DEPTH),
  localparam int CW = IW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pop_en,
  output logic [PW-1:0] pop_data,
  input  logic          push_en,
  input  logic [PW-1:0] push_data,
  input  logic          save_en,
  input  logic          restore_en,
  output logic [CW-1:0] count,
  output logic          empty
);
  logic [PW-1:0] slot_q [DEPTH];
  logic [CW-1:0] head_q, head_d;
  logic [CW-1:0] tail_q, tail_d;
  logic [CW-1:0] mark_q, mark_d;

  assign pop_data = slot_q[head_q[IW-1:0]];
  assign count    = tail_q - head_q;
  assign empty    = (count == '0);

  always_comb begin
    head_d = head_q;
    if (restore_en)
      head_d = mark_q;
    else if (pop_en)
      head_d = head_q + CW'(1);
    tail_d = push_en ? (tail_q + CW'(1)) : tail_q;
    mark_d = save_en ? head_d : mark_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= '0;
      tail_q <= CW'(DEPTH);
      mark_q <= '0;
    end else begin
      head_q <= head_d;
      tail_q <= tail_d;
      mark_q <= mark_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) slot_q[i] <= PW'(BASE + i);
    end else begin
      for (int i = 0; i < DEPTH; i++)
        if (push_en && (tail_q[IW-1:0] == IW'(i))) slot_q[i] <= push_data;
    end
  end
endmodule

// File: rtl/rename_stage.sv
module rename_stage
  import rn_pkg::*;
#(
  parameter int ARCH_N = DEF_ARCH_REGS,
  parameter int PHYS_N = DEF_PHYS_REGS,
  localparam int AW = $clog2(ARCH_N),
  localparam int PW = $clog2(PHYS_N),
  localparam int FREE_N = pool_depth(ARCH_N, PHYS_N),
  localparam int CW = $clog2(FREE_N) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ren_valid,
  input  logic          ren_wr,
  input  logic [AW-1:0] ren_dst,
  input  logic [AW-1:0] ren_src1,
  input  logic [AW-1:0] ren_src2,
  output logic          ren_stall,
  output logic [PW-1:0] ren_src1_phys,
  output logic [PW-1:0] ren_src2_phys,
  output logic [PW-1:0] ren_new_phys,
  output logic [PW-1:0] ren_old_phys,
  input  logic          rel_valid,
  input  logic [PW-1:0] rel_phys,
  input  logic          ckpt_save,
  input  logic          ckpt_restore
);
  logic          needs_reg;
  logic          pool_empty;
  logic          alloc_ok;
  logic          save_ok;
  logic [PW-1:0] head_phys;
  logic [CW-1:0] free_cnt;

  assign needs_reg = ren_valid && ren_wr && (ren_dst != '0);
  assign ren_stall = ren_valid && (ckpt_restore || (needs_reg && pool_empty));
  assign alloc_ok  = needs_reg && !pool_empty && !ckpt_restore;
  assign save_ok   = ckpt_save && !ckpt_restore;
  assign ren_new_phys = alloc_ok ? head_phys : '0;

  rn_map_table #(.ARCH_N(ARCH_N), .PHYS_N(PHYS_N)) map_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_a1      (ren_src1),
    .rd_a2      (ren_src2),
    .rd_a3      (ren_dst),
    .rd_d1      (ren_src1_phys),
    .rd_d2      (ren_src2_phys),
    .rd_d3      (ren_old_phys),
    .wr_en      (alloc_ok),
    .wr_a       (ren_dst),
    .wr_d       (head_phys),
    .save_en    (save_ok),
    .restore_en (ckpt_restore)
  );

  rn_free_list #(.DEPTH(FREE_N), .PW(PW), .BASE(ARCH_N)) pool_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .pop_en     (alloc_ok),
    .pop_data   (head_phys),
    .push_en    (rel_valid),
    .push_data  (rel_phys),
    .save_en    (save_ok),
    .restore_en (ckpt_restore),
    .count      (free_cnt),
    .empty      (pool_empty)
  );
endmodule

// File: rtl/rn_checker.sv
module rn_checker #(
  parameter int AW = 5,
  parameter int PW = 6,
  parameter int CW = 5,
  parameter int DEPTH = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ren_valid,
  input logic          ren_wr,
  input logic [AW-1:0] ren_dst,
  input logic [AW-1:0] ren_src1,
  input logic [PW-1:0] ren_src1_phys,
  input logic          ren_stall,
  input logic [PW-1:0] ren_new_phys,
  input logic          ckpt_restore,
  input logic          rel_valid,
  input logic [CW-1:0] free_cnt
);
  assert_stall_on_empty_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ren_valid && ren_wr && (ren_dst != '0) && (free_cnt == '0)) |-> ren_stall);

  assert_no_needless_stall_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ren_valid && !ckpt_restore && (free_cnt != '0)) |-> !ren_stall);

  assert_zero_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ren_src1 == '0) |-> (ren_src1_phys == '0));

  assert_alloc_nonzero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ren_valid && !ren_stall && ren_wr && (ren_dst != '0)) |-> (ren_new_phys != '0));

  assert_alloc_takes_one_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ren_valid && !ren_stall && ren_wr && (ren_dst != '0) && !rel_valid && !ckpt_restore)
      |=> (free_cnt == $past(free_cnt) - CW'(1)));

  assert_pool_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    free_cnt <= CW'(DEPTH));

  assert_restore_refuses_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ren_valid && ckpt_restore) |-> ren_stall);
endmodule

bind rename_stage rn_checker #(.AW(AW), .PW(PW), .CW(CW), .DEPTH(FREE_N)) chk_i (
  .clk           (clk),
  .rst_n         (rst_n),
  .ren_valid     (ren_valid),
  .ren_wr        (ren_wr),
  .ren_dst       (ren_dst),
  .ren_src1      (ren_src1),
  .ren_src1_phys (ren_src1_phys),
  .ren_stall     (ren_stall),
  .ren_new_phys  (ren_new_phys),
  .ckpt_restore  (ckpt_restore),
  .rel_valid     (rel_valid),
  .free_cnt      (free_cnt)
);

// File: tb/rename_stage_tb_top.sv
`timescale 1ns/1ps
module rename_stage_tb_top;
  logic clk = 1'b0;
  logic rst_n;
  logic ren_valid, ren_wr, rel_valid, ckpt_save, ckpt_restore;
  logic [4:0] ren_dst, ren_src1, ren_src2;
  logic [5:0] rel_phys;
  logic ren_stall;
  logic [5:0] ren_src1_phys, ren_src2_phys, ren_new_phys, ren_old_phys;

  always #2.5 clk = ~clk;

  rename_stage dut_i (
    .clk(clk), .rst_n(rst_n), .ren_valid(ren_valid), .ren_wr(ren_wr),
    .ren_dst(ren_dst), .ren_src1(ren_src1), .ren_src2(ren_src2),
    .ren_stall(ren_stall), .ren_src1_phys(ren_src1_phys),
    .ren_src2_phys(ren_src2_phys), .ren_new_phys(ren_new_phys),
    .ren_old_phys(ren_old_phys), .rel_valid(rel_valid), .rel_phys(rel_phys),
    .ckpt_save(ckpt_save), .ckpt_restore(ckpt_restore)
  );

  int total = 0;
  int bad = 0;
  bit done = 0;

  int mdl_map [32];
  int ck_map [32];
  int free_q [$];
  int snap_q [$];
  int rel_since [$];
  int pend [$];
  int pend_at_save;
  bit ck_active;

  int s_stall, s_src1, s_src2, s_new, s_old;
  bit last_alloc;
  int last_old;

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 32; i++) begin
      mdl_map[i] = i;
      ck_map[i] = i;
    end
    free_q.delete();
    snap_q.delete();
    rel_since.delete();
    pend.delete();
    for (int i = 32; i < 48; i++) begin
      free_q.push_back(i);
      snap_q.push_back(i);
    end
    pend_at_save = 0;
    ck_active = 0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    ren_valid = 0; ren_wr = 0; ren_dst = 0; ren_src1 = 0; ren_src2 = 0;
    rel_valid = 0; rel_phys = 0; ckpt_save = 0; ckpt_restore = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    model_reset();
  endtask

  task automatic step(bit v, bit wr, int dst, int s1, int s2,
                      bit rl, int rp, bit sv, bit rs);
    bit need, es, ea;
    @(negedge clk);
    ren_valid = v; ren_wr = wr; ren_dst = 5'(dst);
    ren_src1 = 5'(s1); ren_src2 = 5'(s2);
    rel_valid = rl; rel_phys = 6'(rp);
    ckpt_save = sv; ckpt_restore = rs;
    #1;
    need = v && wr && (dst != 0);
    es = v && (rs || (need && free_q.size() == 0));
    ea = v && !es && need;
    s_stall = int'(ren_stall);
    s_src1 = int'(ren_src1_phys);
    s_src2 = int'(ren_src2_phys);
    s_new = int'(ren_new_phys);
    s_old = int'(ren_old_phys);
    chk("R7 stall", s_stall, int'(es));
    chk("R3 new register", s_new, ea ? free_q[0] : 0);
    if (v) begin
      chk("R2 source 1", s_src1, mdl_map[s1]);
      chk("R2 source 2", s_src2, mdl_map[s2]);
      chk("R4 old mapping", s_old, mdl_map[dst]);
    end
    last_alloc = ea;
    last_old = mdl_map[dst];
    @(posedge clk);
    if (rs) begin
      mdl_map = ck_map;
      if (rl) rel_since.push_back(rp);
      free_q = snap_q;
      foreach (rel_since[k]) free_q.push_back(rel_since[k]);
    end else begin
      if (ea) mdl_map[dst] = free_q.pop_front();
      if (rl) begin
        free_q.push_back(rp);
        rel_since.push_back(rp);
      end
      if (sv) begin
        ck_map = mdl_map;
        snap_q = free_q;
        rel_since.delete();
      end
    end
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    do_reset();

    // R1: identity map and ascending pool after reset
    step(1, 0, 0, 7, 31, 0, 0, 0, 0);
    chk("R1 reset map src1", s_src1, 7);
    chk("R1 reset map src2", s_src2, 31);
    step(1, 1, 1, 1, 2, 0, 0, 0, 0);
    chk("R1 first allocation", s_new, 32);
    chk("R4 old of r1", s_old, 1);

    // R5: r3 <- r3 + r1
    step(1, 1, 3, 3, 1, 0, 0, 0, 0);
    chk("R5 same register source", s_src1, 3);
    chk("R2 renamed r1 visible", s_src2, 32);
    chk("R1 second allocation", s_new, 33);

    // R6: register zero
    step(1, 1, 0, 0, 0, 0, 0, 0, 0);
    chk("R6 no allocation for r0", s_new, 0);
    chk("R6 r0 reads p0", s_src1, 0);
    step(1, 0, 0, 3, 0, 0, 0, 0, 0);
    chk("R3 r3 now renamed", s_src1, 33);
    step(1, 1, 5, 0, 0, 0, 0, 0, 0);
    chk("R6 pool untouched by r0 write", s_new, 34);

    // drain pool: 35..47
    for (int i = 0; i < 13; i++) step(1, 1, 10, 10, 0, 0, 0, 0, 0);
    chk("R1 last reset entry", s_new, 47);
    step(1, 1, 11, 10, 0, 0, 0, 0, 0);
    chk("R7 stall on empty pool", s_stall, 1);
    step(1, 0, 11, 10, 0, 0, 0, 0, 0);
    chk("R7 no stall without destination", s_stall, 0);
    step(1, 0, 0, 11, 0, 0, 0, 0, 0);
    chk("R7 stalled rename left r11", s_src1, 11);

    // R8: releases and FIFO reuse
    step(1, 1, 11, 0, 0, 1, 1, 0, 0);
    chk("R7 release does not lift stall", s_stall, 1);
    step(0, 0, 0, 0, 0, 1, 3, 0, 0);
    step(1, 1, 12, 0, 0, 0, 0, 0, 0);
    chk("R8 first released reused", s_new, 1);
    step(1, 1, 13, 0, 0, 0, 0, 0, 0);
    chk("R8 second released reused", s_new, 3);

    // R9: checkpoint and restore
    step(0, 0, 0, 0, 0, 1, 10, 0, 0);
    step(0, 0, 0, 0, 0, 1, 35, 0, 0);
    step(1, 1, 14, 0, 0, 0, 0, 1, 0);
    chk("R9 rename in save cycle", s_new, 10);
    step(1, 1, 15, 0, 0, 0, 0, 0, 0);
    chk("R9 allocation after save", s_new, 35);
    step(1, 1, 16, 0, 0, 1, 36, 0, 1);
    chk("R9 rename refused on restore", s_stall, 1);
    chk("R9 no allocation on restore", s_new, 0);
    step(1, 0, 0, 15, 14, 0, 0, 0, 0);
    chk("R9 r15 mapping rolled back", s_src1, 15);
    chk("R9 r14 mapping kept", s_src2, 10);
    step(1, 1, 17, 0, 0, 0, 0, 0, 0);
    chk("R9 head rolled back", s_new, 35);
    step(1, 1, 18, 0, 0, 0, 0, 0, 0);
    chk("R8 release in restore cycle kept", s_new, 36);

    // random legal stream
    do_reset();
    for (int n = 0; n < 4000; n++) begin
      bit v, wr, rl, sv, rs, allowed;
      int dst, s1, s2, rp;
      v = ($urandom % 4) != 0;
      wr = ($urandom % 3) != 0;
      dst = $urandom % 32;
      s1 = $urandom % 32;
      s2 = $urandom % 32;
      allowed = (pend.size() > 0) && (!ck_active || pend_at_save > 0);
      rl = allowed && (($urandom % 3) == 0 || free_q.size() < 2);
      rp = rl ? pend[0] : 0;
      rs = ck_active && (($urandom % 40) == 0);
      sv = !rs && (($urandom % 30) == 0);
      step(v, wr, dst, s1, s2, rl, rp, sv, rs);
      if (rl) begin
        void'(pend.pop_front());
        if (ck_active && pend_at_save > 0) pend_at_save--;
      end
      if (rs) begin
        while (pend.size() > pend_at_save) void'(pend.pop_back());
      end else begin
        if (last_alloc) pend.push_back(last_old);
        if (sv) begin
          ck_active = 1;
          pend_at_save = pend.size();
        end
      end
      if (ck_active && !sv && !rs && (($urandom % 25) == 0)) ck_active = 0;
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule